// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a single-port synchronous static RAM with a pipelined read path. It accepts one access per clock edge and lets reads and writes follow each other in any order with no idle cycle between them. The address and command of an access are captured on one rising edge. The data of that access uses the shared bidirectional bus one enabled edge later, and the bus master samples it on the edge after that. A write therefore supplies its data in the same bus slot that a read would use, which is what removes the turnaround gap.

Three synchronous chip selects qualify each cycle. An active-low clock enable freezes the whole pipeline. Active-low lane write selects limit a write to chosen 9-bit byte lanes. The bus drivers turn on only during a read's data slot, and only while the asynchronous active-low output enable is low. If a read follows a write to the same word whose data has not yet reached the array, the read returns the new data, merged lane by lane.

Top module: `nwait_sram`

## Requirements
- R1: A cycle is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at the enabled edge. Any other combination does no access, changes no word and leaves the bus undriven in that cycle's data slot.
- R2: For a read whose address is sampled at enabled edge n, the block drives the word on `dq` from just after enabled edge n+1 until enabled edge n+2, where the master samples it.
- R3: For a write whose address is sampled at enabled edge n, the data is taken from `dq` at enabled edge n+2 and stored at that address.
- R4: Lane i occupies `dq[9i+8:9i]`. A write changes lane i only when `lane_wr_n[i]`=0, and every other lane keeps its old contents.
- R5: Reads and writes to any addresses may be issued on consecutive enabled edges in any order, with no idle cycle, and each returns or stores the correct data.
- R6: A read issued on the enabled edge directly after a write to the same address returns the written lanes merged over the stored word.
- R7: An edge at which `clk_en_n`=1 samples no input, and every pipeline register holds its value. The data slot in progress, including driven read data, is stretched until the next enabled edge.
- R8: During a write's data slot the block never drives `dq`, whatever the level of `out_en_n`.
- R9: The drivers are on only while `out_en_n`=0 and a read's data slot is active. Raising `out_en_n` releases the bus at once, without any clock edge.
- R10: After reset no access is pending and `dq` is undriven. Any data slot that does not belong to a read leaves `dq` undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Low for a write, high for a read |
| lane_wr_n | input | LANES | Active-low per-lane write selects |
| addr | input | ADDR_W | Word address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | LANE_W*LANES | Shared data bus |

## Verification
The conflicting pair is the mid-pipeline write and the read behind it. When a write is directly followed by a read of the same word, the array update and the read of that word fall on the same enabled edge. The bench provokes this for all sixteen lane-select patterns and compares the returned word with a lane merge it computes itself. The second pair is the bus direction change: a read slot is directly followed by a write slot on the same word. The bench keeps the bus driven with a known value whenever the block must be silent. Any stray drive then corrupts either the sampled bus or the stored word, and a later readback reveals it.

// File: rtl/nwait_sram_pkg.sv
package nwait_sram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_kind_e;

   // A cycle is taken only with the select triple in its active state.
   function automatic op_kind_e decode_op(input logic a_n, input logic b,
                                          input logic c_n, input logic wrn);
      if (a_n || !b || c_n) return OP_IDLE;
      return wrn ? OP_READ : OP_WRITE;
   endfunction

endpackage

// File: rtl/nwait_sram_pipe.sv
module nwait_sram_pipe
   import nwait_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   output op_kind_e          s1_kind,
   output logic [ADDR_W-1:0] s1_addr,
   output op_kind_e          s2_kind,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_lanes
);

   logic [LANES-1:0] s1_lanes;
   op_kind_e         in_kind;

   assign in_kind = decode_op(sel_a_n, sel_b, sel_c_n, wr_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_kind  <= OP_IDLE;
         s1_addr  <= '0;
         s1_lanes <= '0;
         s2_kind  <= OP_IDLE;
         s2_addr  <= '0;
         s2_lanes <= '0;
      end else if (!hold) begin
         s1_kind  <= in_kind;
         s1_addr  <= addr;
         s1_lanes <= ~lane_wr_n;
         s2_kind  <= s1_kind;
         s2_addr  <= s1_addr;
         s2_lanes <= s1_lanes;
      end
   end

   // R1
   desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && (sel_a_n || !sel_b || sel_c_n)) |=> (s1_kind == OP_IDLE));

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(s1_kind) && $stable(s2_kind) &&
                $stable(s1_addr) && $stable(s2_addr) && $stable(s2_lanes)));

   // R5
   stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> ((s2_kind == $past(s1_kind)) && (s2_addr == $past(s1_addr))));

endmodule

// File: rtl/nwait_sram_store.sv
module nwait_sram_store #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [LANES-1:0]         wlanes,
   input  logic [LANE_W*LANES-1:0]  wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [LANE_W*LANES-1:0]  rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wlanes[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
   end

endmodule

// File: rtl/nwait_sram_merge.sv
module nwait_sram_merge #(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter bit FWD_EN = 1'b1
) (
   input  logic                     hit,
   input  logic [LANES-1:0]         lanes,
   input  logic [LANE_W*LANES-1:0]  bus_q,
   input  logic [LANE_W*LANES-1:0]  mem_q,
   output logic [LANE_W*LANES-1:0]  rd_q
);

   if (FWD_EN) begin : g_fwd
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign rd_q[g*LANE_W +: LANE_W] = (hit && lanes[g]) ?
                                           bus_q[g*LANE_W +: LANE_W] :
                                           mem_q[g*LANE_W +: LANE_W];
      end
   end else begin : g_nofwd
      logic unused_fwd;
      assign unused_fwd = hit ^ (^lanes) ^ (^bus_q);
      assign rd_q = mem_q;
   end

endmodule

// File: rtl/nwait_sram_drive.sv
module nwait_sram_drive #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              load_rd,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drv
);

   logic rd_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_phase <= 1'b0;
         dq_out   <= '0;
      end else if (!hold) begin
         rd_phase <= load_rd;
         if (load_rd) dq_out <= rd_data;
      end
   end

   assign dq_drv = rd_phase & ~out_en_n;

   // R2
   rd_slot_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && load_rd) |=> rd_phase);

   // R10
   rd_slot_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !load_rd) |=> !rd_phase);

   // R7
   rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(dq_out) && $stable(rd_phase)));

endmodule

// File: rtl/nwait_sram.sv
module nwait_sram
   import nwait_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter bit FWD_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clk_en_n,
   input  logic                     sel_a_n,
   input  logic                     sel_b,
   input  logic                     sel_c_n,
   input  logic                     wr_n,
   input  logic [LANES-1:0]         lane_wr_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     out_en_n,
   inout  wire  [LANE_W*LANES-1:0]  dq
);

   localparam int DATA_W = LANE_W * LANES;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("nwait_sram: ADDR_W must lie in 1..12");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lanes
      $error("nwait_sram: LANE_W and LANES must be positive");
   end

   op_kind_e          s1_kind;
   op_kind_e          s2_kind;
   logic [ADDR_W-1:0] s1_addr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_lanes;
   logic [DATA_W-1:0] bus_in;
   logic [DATA_W-1:0] mem_q;
   logic [DATA_W-1:0] rd_q;
   logic [DATA_W-1:0] dq_out;
   logic              dq_drv;
   logic              wr_slot;
   logic              raw_hit;

   nwait_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (clk_en_n),
      .sel_a_n   (sel_a_n),
      .sel_b     (sel_b),
      .sel_c_n   (sel_c_n),
      .wr_n      (wr_n),
      .lane_wr_n (lane_wr_n),
      .addr      (addr),
      .s1_kind   (s1_kind),
      .s1_addr   (s1_addr),
      .s2_kind   (s2_kind),
      .s2_addr   (s2_addr),
      .s2_lanes  (s2_lanes)
   );

   assign bus_in  = dq;
   assign wr_slot = (s2_kind == OP_WRITE);
   assign raw_hit = wr_slot && (s2_addr == s1_addr);

   nwait_sram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
      .clk    (clk),
      .we     (wr_slot && !clk_en_n),
      .waddr  (s2_addr),
      .wlanes (s2_lanes),
      .wdata  (bus_in),
      .raddr  (s1_addr),
      .rdata  (mem_q)
   );

   nwait_sram_merge #(.LANE_W(LANE_W), .LANES(LANES), .FWD_EN(FWD_EN)) u_merge (
      .hit   (raw_hit),
      .lanes (s2_lanes),
      .bus_q (bus_in),
      .mem_q (mem_q),
      .rd_q  (rd_q)
   );

   nwait_sram_drive #(.DATA_W(DATA_W)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (clk_en_n),
      .load_rd  (s1_kind == OP_READ),
      .rd_data  (rd_q),
      .out_en_n (out_en_n),
      .dq_out   (dq_out),
      .dq_drv   (dq_drv)
   );

   assign dq = dq_drv ? dq_out : {DATA_W{1'bz}};

   // R8
   wr_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_slot |-> !dq_drv);

endmodule

// File: tb/nwait_sram_tb.sv
module nwait_sram_tb;

   localparam int CLK_P = 10;
   localparam int AW    = 6;
   localparam int NW    = 1 << AW;
   localparam int DW    = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          sel_a_n = 1'b1;
   logic          sel_b = 1'b0;
   logic          sel_c_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [3:0]    lane_wr_n = 4'hF;
   logic [AW-1:0] addr = '0;
   logic          out_en_n = 1'b0;
   logic          tb_drv = 1'b1;
   logic [DW-1:0] tb_q = '0;
   wire  [DW-1:0] dq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [DW-1:0] model [NW];
   int            hk [2];
   int            ha [2];
   logic [DW-1:0] hd [2];
   string         hr [2];

   assign dq = tb_drv ? tb_q : {DW{1'bz}};

   always #(CLK_P/2) clk = ~clk;

   nwait_sram u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en_n  (clk_en_n),
      .sel_a_n   (sel_a_n),
      .sel_b     (sel_b),
      .sel_c_n   (sel_c_n),
      .wr_n      (wr_n),
      .lane_wr_n (lane_wr_n),
      .addr      (addr),
      .out_en_n  (out_en_n),
      .dq        (dq)
   );

   function automatic logic [DW-1:0] pat(input int a, input int k);
      logic [63:0] v;
      v = 64'(a + 1) * 64'h1234_5679 + 64'(k) * 64'h0777_1113 + 64'(a * k) * 64'h3B;
      return v[DW-1:0] | 36'h1;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock of stimulus. kind: 0 idle, 1 read, 2 write. ce = {sel_a_n, sel_b, sel_c_n}.
   task automatic step(input bit en, input int kind, input int a, input logic [3:0] lmask,
                       input logic [DW-1:0] d, input logic [2:0] ce, input bit oe_n,
                       input string tag);
      int eff;
      @(negedge clk);
      out_en_n = oe_n;
      if (hk[1] == 2) begin
         tb_drv = 1'b1; tb_q = hd[1];
      end else if (hk[1] == 1 && !oe_n) begin
         tb_drv = 1'b0;
      end else begin
         tb_drv = 1'b1; tb_q = '0;
      end
      clk_en_n  = !en;
      {sel_a_n, sel_b, sel_c_n} = ce;
      wr_n      = (kind != 2);
      lane_wr_n = ~lmask;
      addr      = AW'(a);
      #1;
      if (hk[1] == 1 && !oe_n) chk(dq === hd[1], hr[1], dq, hd[1]);
      else if (hk[1] != 2)     chk(dq === '0, hr[1], dq, '0);
      if (en) begin
         eff = (ce == 3'b010) ? ((kind == 2) ? 2 : 1) : 0;
         hk[1] = hk[0]; ha[1] = ha[0]; hd[1] = hd[0]; hr[1] = hr[0];
         hk[0] = eff; ha[0] = a; hr[0] = tag;
         if (eff == 2) begin
            for (int i = 0; i < 4; i++)
               if (lmask[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
            hd[0] = d;
         end else if (eff == 1) begin
            hd[0] = model[a];
         end else begin
            hd[0] = '0;
         end
      end
   endtask

   task automatic wr(input int a, input logic [3:0] m, input logic [DW-1:0] d, input string tag);
      step(1'b1, 2, a, m, d, 3'b010, 1'b0, tag);
   endtask

   task automatic rd(input int a, input string tag);
      step(1'b1, 1, a, 4'h0, '0, 3'b010, 1'b0, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b1, 0, 0, 4'h0, '0, 3'b100, 1'b0, tag);
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         hk[i] = 0; ha[i] = 0; hd[i] = '0; hr[i] = "R10";
      end
      for (int i = 0; i < NW; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: bus released straight after reset
      chk(dq === '0, "R10", dq, '0);
      idle("R10"); idle("R10"); idle("R10");

      // R3 then R2: fill every word, then read every word back to back
      for (int a = 0; a < NW; a++) wr(a, 4'hF, pat(a, 0), "R3");
      for (int a = 0; a < NW; a++) rd(a, "R2");
      idle("R2"); idle("R2");

      // R5: alternate write and read of another word on every cycle
      for (int a = 0; a < NW; a++) begin
         wr(a, 4'hF, pat(a, 1), "R5");
         rd((a + 17) % NW, "R5");
      end
      for (int a = 0; a < NW; a++) rd(a, "R5");
      idle("R5"); idle("R5");

      // R6 and R4: every lane mask, read right behind the write and again later
      for (int m = 0; m < 16; m++) begin
         wr(5, 4'hF, pat(m, 2), "R4");
         wr(5, 4'(m), pat(m, 3), "R4");
         rd(5, "R6");
         idle("R4");
         rd(5, "R4");
      end
      idle("R4"); idle("R4");

      // R1: only select pattern 010 may write; deselected reads leave the bus alone
      wr(9, 4'hF, pat(99, 4), "R1");
      for (int c = 0; c < 8; c++)
         step(1'b1, 2, 9, 4'hF, pat(c, 4), 3'(c), 1'b0, "R1");
      for (int c = 0; c < 8; c++)
         step(1'b1, 1, 9, 4'h0, '0, 3'(c), 1'b0, "R1");
      rd(9, "R1");
      idle("R1"); idle("R1");

      // R7: stalls during a write slot and during a read slot
      wr(20, 4'hF, pat(1, 5), "R7");
      rd(20, "R7");
      for (int s = 0; s < 3; s++) step(1'b0, 2, 20, 4'hF, pat(2, 5), 3'b010, 1'b0, "R7");
      idle("R7");
      for (int s = 0; s < 3; s++) step(1'b0, 2, 20, 4'hF, pat(3, 5), 3'b010, 1'b0, "R7");
      idle("R7");
      rd(20, "R7");
      idle("R7"); idle("R7");

      // R9: output enable high during a read slot releases the bus
      wr(30, 4'hF, pat(7, 6), "R9");
      rd(30, "R9");
      idle("R9");
      step(1'b1, 0, 0, 4'h0, '0, 3'b100, 1'b1, "R9");
      rd(30, "R9");
      idle("R9"); idle("R9");

      // R8: read slot followed at once by a write slot on the same word
      wr(40, 4'hF, pat(4, 7), "R8");
      idle("R8");
      rd(40, "R8");
      wr(40, 4'hF, pat(5, 7) & 36'h0_F0F0_F0F1, "R8");
      rd(40, "R8");
      idle("R8");
      rd(40, "R8");
      idle("R8"); idle("R8");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule